// File: doc/BRIEF.md
# Two-Wire Register Slave with Strap-Controlled Spike Filter

This block is a slave on a two-wire serial bus (SCL clock, open-drain SDA data) that lets a bus host read and write a bank of 8-bit control registers held outside the block. After a start condition it receives an address byte. If the address is its own, it acknowledges and then either takes a register pointer followed by write data, or returns register contents to the host. The pointer advances after every data byte, so bursts of reads and writes touch consecutive registers.

A single strap pin does two jobs. It supplies one bit of the slave address, so two slaves can share a bus. When the strap is high, it also turns on a digital spike filter on both bus lines. The filter only accepts a new line level once that level has stayed steady for `FILT_CYC` system clocks, which should be set to cover 50 ns. When the strap is low, the filtered path is bypassed and only the two-flop synchroniser remains.

The register file connects through a write strobe with address and data, plus a read address whose data is expected back on `rd_data_i` (combinational or already settled). All bus activity is sampled on the system clock. Clock stretching, 10-bit addressing and general call are not handled.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0, `wr_en_o` is 0 and the register pointer `rd_addr_o` is 0.
- R2: A start condition is SDA falling while SCL is high. After it, the slave samples 8 bits on SCL rising edges, most significant bit first: a 7-bit address, then a direction bit (0 = write, 1 = read). If the address equals `SLV_ADDR` with bit `STRAP_POS` replaced by the strap level, the slave drives SDA low (`sda_oe_o` = 1) through the ninth clock.
- R3: On an address mismatch the slave never drives SDA and issues no write until the next start condition.
- R4: In a write, the first byte after the address acknowledge is a subaddress. Its low `REG_AW` bits load the register pointer, and the slave acknowledges it.
- R5: Each later byte of a write is acknowledged and causes exactly one single-cycle `wr_en_o` pulse with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. The pointer then increments modulo 2^`REG_AW`, so 15 is followed by 0 with `REG_AW` = 4.
- R6: In a read, the slave sends the register at the pointer MSB first. It changes SDA only while SCL is low, and the pointer increments once per byte sent.
- R7: If the host acknowledges a read byte, the next register follows. If the host does not acknowledge, the slave releases SDA and ignores all SCL pulses until the next start.
- R8: A repeated start re-enters address reception and keeps the pointer, so a write of a subaddress followed by a repeated-start read returns data from that subaddress.
- R9: A stop condition (SDA rising while SCL is high) returns the slave to idle. Bytes clocked after it without a new start are not acknowledged.
- R10: With the strap high, a pulse of fewer than `FILT_CYC` clocks on SCL or SDA has no effect on the transfer in progress.
- R11: With the strap low the filter is bypassed. A 2-clock low pulse on SDA while SCL is high is taken as a start followed by a stop, so the byte in progress is not acknowledged and not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Address strap; high also enables the spike filter |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| wr_en_o | output | 1 | Register write strobe, one cycle |
| wr_addr_o | output | REG_AW | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | REG_AW | Register pointer, used as read address |
| rd_data_i | input | 8 | Register read data for `rd_addr_o` |

## Verification
The bench builds the block with `FILT_CYC` = 4 and the default `REG_AW` = 4. With these values a 2-clock pulse is clearly shorter than the acceptance window, so the same pulse can be shown rejected with the strap high and taken as bus conditions with the strap low. A 16-register bank also makes the pointer wrap from 15 to 0 reachable in a two-byte burst. The bench drives bus bit times of 64 clocks, long enough that the synchroniser and filter latency never overlaps an SCL edge.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_END, S_ACK_A, S_SUB, S_SUB_END, S_ACK_S,
    S_WR, S_WR_END, S_TX, S_TX_END, S_MACK, S_TX_LOAD
  } slv_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic scl;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic filt_en,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_r;
  logic          sync_v;
  logic [CW-1:0] cnt;

  assign sync_v = sync_r[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r <= 2'b11;
      cnt    <= '0;
      line_o <= 1'b1;
    end else begin
      sync_r <= {sync_r[0], line_i};
      if (!filt_en) begin
        line_o <= sync_v;
        cnt    <= '0;
      end else if (sync_v == line_o) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        line_o <= sync_v;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  generate
    if (FILT_CYC >= 2) begin : g_filt_chk
      // R10
      filt_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_en && $past(filt_en) && line_o != $past(line_o)) |->
          ($past(sync_v) == line_o && $past(sync_v, 2) == line_o));
    end
  endgenerate
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import i2c_slv_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_f,
  input  logic    sda_f,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    ev.scl   = scl_f;
    ev.sda   = sda_f;
    ev.rise  = scl_f & ~scl_q;
    ev.fall  = ~scl_f & scl_q;
    ev.start = scl_f & scl_q & sda_q & ~sda_f;
    ev.stop  = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR  = 7'h56,
  parameter int         STRAP_POS = 1,
  parameter int         REG_AW    = 4,
  parameter int         DW        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  bus_ev_t           ev,
  input  logic [DW-1:0]     rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [REG_AW-1:0] ptr
);
  localparam int          CW   = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  slv_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, tx;
  logic          rw;
  logic [6:0]    addr_eff;

  always_comb begin
    addr_eff            = SLV_ADDR;
    addr_eff[STRAP_POS] = strap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev.stop) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (ev.start) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_SUB, S_WR: if (ev.rise) begin
            sh  <= {sh[DW-2:0], ev.sda};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              if (state == S_ADDR)     state <= S_ADDR_END;
              else if (state == S_SUB) state <= S_SUB_END;
              else                     state <= S_WR_END;
            end
          end
          S_ADDR_END: if (ev.fall) begin
            if (sh[DW-1:1] == addr_eff) begin
              rw     <= sh[0];
              sda_oe <= 1'b1;
              state  <= S_ACK_A;
            end else begin
              state <= S_IDLE;
            end
          end
          S_ACK_A: if (ev.fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_SUB;
            end
          end
          S_SUB_END: if (ev.fall) begin
            ptr    <= sh[REG_AW-1:0];
            sda_oe <= 1'b1;
            state  <= S_ACK_S;
          end
          S_ACK_S: if (ev.fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= S_WR;
          end
          S_WR_END: if (ev.fall) begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= sh;
            ptr     <= ptr + 1'b1;
            sda_oe  <= 1'b1;
            state   <= S_ACK_S;
          end
          S_TX: begin
            if (ev.rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST) begin
                state <= S_TX_END;
                ptr   <= ptr + 1'b1;
              end
            end else if (ev.fall) begin
              tx     <= {tx[DW-2:0], 1'b0};
              sda_oe <= ~tx[DW-2];
            end
          end
          S_TX_END: if (ev.fall) begin
            sda_oe <= 1'b0;
            state  <= S_MACK;
          end
          S_MACK: if (ev.rise) begin
            state <= ev.sda ? S_IDLE : S_TX_LOAD;
          end
          S_TX_LOAD: if (ev.fall) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[DW-1];
            cnt    <= '0;
            state  <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_oe);

  // R6
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !ev.scl);

  // R2
  ack_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACK_A) |-> sda_oe);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR  = 7'h56,
  parameter int         STRAP_POS = 1,
  parameter int         REG_AW    = 4,
  parameter int         FILT_CYC  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [REG_AW-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int NLINES = 2;

  logic [1:0]        strap_s;
  logic [NLINES-1:0] raw, filt;
  bus_ev_t           ev;

  always_ff @(posedge clk) begin
    if (rst) strap_s <= 2'b00;
    else     strap_s <= {strap_s[0], strap_i};
  end

  assign raw = {sda_i, scl_i};

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst(rst), .filt_en(strap_s[1]),
        .line_i(raw[i]), .line_o(filt[i]));
    end
  endgenerate

  i2c_bus_events u_ev (
    .clk(clk), .rst(rst), .scl_f(filt[0]), .sda_f(filt[1]), .ev(ev));

  i2c_slave_ctrl #(
    .SLV_ADDR(SLV_ADDR), .STRAP_POS(STRAP_POS), .REG_AW(REG_AW), .DW(8)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strap(strap_s[1]), .ev(ev), .rd_data(rd_data_i),
    .sda_oe(sda_oe_o), .wr_en(wr_en_o), .wr_addr(wr_addr_o),
    .wr_data(wr_data_o), .ptr(rd_addr_o));
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int Q = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_line;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  logic [11:0] exp_wr [$];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  i2c_reg_slave #(.SLV_ADDR(7'h56), .STRAP_POS(1), .REG_AW(AW), .FILT_CYC(4)) u_dut (
    .clk(clk), .rst(rst), .strap_i(strap), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h30 + 8'(i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the write port against the reference queue (R5)
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R5 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [11:0] e;
        e = exp_wr.pop_front();
        chk({wr_addr, wr_data} == e, "R5 write addr/data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  // gkind: 0 none, 1 short low pulse on SDA, 2 short low pulse on SCL
  task automatic send_bit(input bit b, input int gkind);
    sda_m = b; wt(Q);
    scl_m = 1'b1;
    if (gkind == 1) begin
      wt(Q); sda_m = 1'b0; wt(2); sda_m = 1'b1; wt(Q - 2);
    end else if (gkind == 2) begin
      wt(Q); scl_m = 1'b0; wt(2); scl_m = 1'b1; wt(Q - 2);
    end else begin
      wt(2 * Q);
    end
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    b = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gbit, input int gkind, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == gbit) ? gkind : 0);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~mack, 0);
  endtask

  task automatic exp_write(input int a, input logic [7:0] d);
    exp_wr.push_back({4'(a), d});
    exp_mem[a] = d;
  endtask

  initial begin
    bit ack;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'h30 + 8'(i);
    wt(10); rst = 1'b0; wt(4);

    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
    chk(rd_addr == 0, "R1 pointer after reset", rd_addr, 0);

    // burst write at 3..5, strap high -> address 0x56
    bus_start();
    send_byte({7'h56, 1'b0}, -1, 0, ack); chk(ack, "R2 address ack", ack, 1);
    send_byte(8'h03, -1, 0, ack); chk(ack, "R4 subaddress ack", ack, 1);
    exp_write(3, 8'h11); send_byte(8'h11, -1, 0, ack); chk(ack, "R5 data ack", ack, 1);
    exp_write(4, 8'h22); send_byte(8'h22, -1, 0, ack); chk(ack, "R5 data ack", ack, 1);
    exp_write(5, 8'hC3); send_byte(8'hC3, -1, 0, ack); chk(ack, "R5 data ack", ack, 1);
    bus_stop(); wt(20);
    chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
    chk(mem[5] == 8'hC3, "R5 register 5", mem[5], 8'hC3);

    // subaddress then repeated-start read of 4,5,6
    bus_start();
    send_byte({7'h56, 1'b0}, -1, 0, ack);
    send_byte(8'h04, -1, 0, ack);
    bus_start();
    send_byte({7'h56, 1'b1}, -1, 0, ack); chk(ack, "R8 read address ack after repeated start", ack, 1);
    recv_byte(1'b1, v); chk(v == exp_mem[4], "R8 R6 first read byte", v, exp_mem[4]);
    recv_byte(1'b1, v); chk(v == exp_mem[5], "R7 acked read continues", v, exp_mem[5]);
    recv_byte(1'b0, v); chk(v == exp_mem[6], "R6 third read byte", v, exp_mem[6]);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 9; i++) begin recv_bit(ack); if (!ack) quiet = 1'b0; end
      chk(quiet, "R7 released after host nack", quiet, 1);
    end
    bus_stop();

    // read without subaddress continues at pointer 7
    bus_start();
    send_byte({7'h56, 1'b1}, -1, 0, ack);
    recv_byte(1'b0, v); chk(v == exp_mem[7], "R6 pointer advanced per byte", v, exp_mem[7]);
    bus_stop();

    // wrong address
    bus_start();
    send_byte({7'h20, 1'b0}, -1, 0, ack); chk(!ack, "R3 mismatch not acked", ack, 0);
    send_byte(8'h00, -1, 0, ack); chk(!ack, "R3 ignored byte", ack, 0);
    send_byte(8'h99, -1, 0, ack); chk(!ack, "R3 ignored byte", ack, 0);
    bus_stop();

    // bytes after stop without a start
    send_byte({7'h56, 1'b0}, -1, 0, ack); chk(!ack, "R9 no start no ack", ack, 0);
    bus_stop(); wt(20);
    chk(mem[0] == exp_mem[0], "R3 R9 register 0 untouched", mem[0], exp_mem[0]);

    // pointer wrap 15 -> 0
    bus_start();
    send_byte({7'h56, 1'b0}, -1, 0, ack);
    send_byte(8'hFF, -1, 0, ack);
    exp_write(15, 8'h5A); send_byte(8'h5A, -1, 0, ack);
    exp_write(0, 8'h6B); send_byte(8'h6B, -1, 0, ack);
    bus_stop(); wt(20);
    chk(mem[0] == 8'h6B, "R5 pointer wraps to 0", mem[0], 8'h6B);

    // spike filter on: short pulses have no effect
    bus_start();
    send_byte({7'h56, 1'b0}, -1, 0, ack);
    send_byte(8'h08, -1, 0, ack);
    exp_write(8, 8'hFF); send_byte(8'hFF, 3, 1, ack); chk(ack, "R10 SDA spike rejected", ack, 1);
    exp_write(9, 8'h81); send_byte(8'h81, 4, 2, ack); chk(ack, "R10 SCL spike rejected", ack, 1);
    bus_stop(); wt(20);
    chk(mem[9] == 8'h81, "R10 data intact after SCL spike", mem[9], 8'h81);

    // strap low: address bit 1 cleared, filter bypassed
    strap = 1'b0; wt(10);
    bus_start();
    send_byte({7'h56, 1'b0}, -1, 0, ack); chk(!ack, "R2 strap low rejects 0x56", ack, 0);
    bus_stop();
    bus_start();
    send_byte({7'h54, 1'b0}, -1, 0, ack); chk(ack, "R2 strap low accepts 0x54", ack, 1);
    send_byte(8'h0A, -1, 0, ack);
    exp_write(10, 8'h77); send_byte(8'h77, -1, 0, ack);
    send_byte(8'hFF, 3, 1, ack); chk(!ack, "R11 spike seen as start/stop", ack, 0);
    bus_stop(); wt(20);
    chk(mem[11] == exp_mem[11], "R11 no write after spike", mem[11], exp_mem[11]);
    chk(exp_wr.size() == 0, "R5 write queue drained", exp_wr.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule